// File: doc/BRIEF.md
# Combinational ALU with One-Hot Operation Select

This block is the integer execute unit of a simple 32-bit load/store datapath. It reads two operands and a one-hot operation vector and produces one result word with no clock and no state. The operations are addition, subtraction, four bitwise functions (AND, OR, XOR, NOR), unsigned and signed set-on-less-than, and three shifts: logical left, logical right and arithmetic right.

The caller raises at most one select bit. Each shift moves the second operand `opB` by a separate 5-bit shift amount. A compare writes a whole result word, either the value one or zero. The block has no flag outputs.

Top module: `alu_onehot`

## Requirements
- R1: When select bit 0 (add) is raised, `result` equals `opA + opB` modulo 2^32.
- R2: When select bit 5 (sub) is raised, `result` equals `opA - opB` modulo 2^32.
- R3: When select bit 1 (and), bit 2 (xor) or bit 3 (or) is raised, `result` is the bitwise AND, XOR or OR of the operands.
- R4: When select bit 4 (nor) is raised, `result` is the bitwise inverse of `opA | opB`.
- R5: When select bit 6 (unsigned less-than) is raised, `result` is 1 if `opA < opB` as unsigned numbers, else 0.
- R6: When select bit 7 (signed less-than) is raised, `result` is 1 if `opA < opB` in two's complement, else 0. This holds also when `opA - opB` overflows.
- R7: A compare result always has bits 31 to 1 at zero. Only bit 0 carries the outcome.
- R8: When select bit 9 (logical right shift) is raised, `result` is `opB` shifted right by `shAmt`, with zeros entering at the top.
- R9: When select bit 8 (arithmetic right shift) is raised, `result` is `opB` shifted right by `shAmt`, with copies of `opB[31]` entering at the top.
- R10: When select bit 10 (left shift) is raised, `result` is `opB` shifted left by `shAmt`, with zeros entering at the bottom.
- R11: Shifts act on `opB` only, and `opA` does not affect them. `shAmt` is unsigned and covers 0 to 31. A shift by 0 returns `opB` unchanged.
- R12: When no select bit is raised, `result` is all zeros.
- R13: The block is purely combinational. `result` follows its inputs within the same cycle, with no clock or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand; the shifted value for all shifts |
| opSel | input | 11 | One-hot select: 0 add, 1 and, 2 xor, 3 or, 4 nor, 5 sub, 6 sltu, 7 slt, 8 sra, 9 srl, 10 sll |
| shAmt | input | 5 | Unsigned shift distance |
| result | output | 32 | Selected operation result |

## Verification
The block holds no state, so any fault appears on `result` in the same cycle as the input pattern that exposes it. A wrong strobe from the control module shows as a second operation's value ORed into the result, or as a missing result. A wrong carry-in or operand inversion shows only in the subtract and compare paths. The edge operands (zero, one, all-ones, the most negative and the most positive value) bring out these faults, as do shift distances 0 and 31. Signed compares across an overflowing difference check the sign-selection logic.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int NUM_OPS = 11;

  localparam int OP_ADD  = 0;
  localparam int OP_AND  = 1;
  localparam int OP_XOR  = 2;
  localparam int OP_OR   = 3;
  localparam int OP_NOR  = 4;
  localparam int OP_SUB  = 5;
  localparam int OP_SLTU = 6;
  localparam int OP_SLT  = 7;
  localparam int OP_SRA  = 8;
  localparam int OP_SRL  = 9;
  localparam int OP_SLL  = 10;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic invertB;   // subtract path: ~b plus carry-in 1
    logic useSum;    // drive adder output onto result
    logic useAnd;
    logic useOr;
    logic useXor;
    logic useNor;
    logic useLtU;
    logic useLtS;
    logic useShift;  // drive shifter output onto result
    logic shLeft;
    logic shArith;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [NUM_OPS-1:0] opSel,
  output aluStrobe_t         strobe
);

  always_comb begin
    strobe          = '0;
    strobe.invertB  = opSel[OP_SUB] | opSel[OP_SLT] | opSel[OP_SLTU];
    strobe.useSum   = opSel[OP_ADD] | opSel[OP_SUB];
    strobe.useAnd   = opSel[OP_AND];
    strobe.useOr    = opSel[OP_OR];
    strobe.useXor   = opSel[OP_XOR];
    strobe.useNor   = opSel[OP_NOR];
    strobe.useLtU   = opSel[OP_SLTU];
    strobe.useLtS   = opSel[OP_SLT];
    strobe.useShift = opSel[OP_SRA] | opSel[OP_SRL] | opSel[OP_SLL];
    strobe.shLeft   = opSel[OP_SLL];
    strobe.shArith  = opSel[OP_SRA];
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amount,
  input  logic             shLeft,
  input  logic             shArith,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] dinRev;
  logic [WIDTH-1:0] stageIn;
  logic [WIDTH-1:0] stageOut;
  logic [WIDTH-1:0] outRev;
  logic             fillBit;
  logic [WIDTH-1:0] stage [0:SHW];

  // A left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign dinRev[i] = din[WIDTH-1-i];
    assign outRev[i] = stageOut[WIDTH-1-i];
  end

  assign stageIn  = shLeft ? dinRev : din;
  assign fillBit  = shArith & din[WIDTH-1];
  assign stage[0] = stageIn;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign stage[s+1] = amount[s]
                      ? {{DIST{fillBit}}, stage[s][WIDTH-1:DIST]}
                      : stage[s];
  end

  assign stageOut = stage[SHW];
  assign dout     = shLeft ? outRev : stageOut;

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shAmt,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] bOperand;
  logic [WIDTH:0]   sumFull;
  logic [WIDTH-1:0] sumVal;
  logic             carryOut;
  logic             signsDiffer;
  logic             lessU;
  logic             lessS;
  logic [WIDTH-1:0] shiftVal;

  assign bOperand = strobe.invertB ? ~opB : opB;
  assign sumFull  = {1'b0, opA} + {1'b0, bOperand}
                  + {{WIDTH{1'b0}}, strobe.invertB};
  assign sumVal   = sumFull[WIDTH-1:0];
  assign carryOut = sumFull[WIDTH];

  // a - b borrows exactly when a < b unsigned.
  assign lessU       = ~carryOut;
  // With different signs the negative operand is smaller, so no overflow matters.
  assign signsDiffer = opA[WIDTH-1] ^ opB[WIDTH-1];
  assign lessS       = signsDiffer ? opA[WIDTH-1] : sumVal[WIDTH-1];

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .din     (opB),
    .amount  (shAmt),
    .shLeft  (strobe.shLeft),
    .shArith (strobe.shArith),
    .dout    (shiftVal)
  );

  // AND-OR result select: one-hot strobes, zero when none is set.
  always_comb begin
    result = ({WIDTH{strobe.useSum}}   & sumVal)
           | ({WIDTH{strobe.useAnd}}   & (opA & opB))
           | ({WIDTH{strobe.useOr}}    & (opA | opB))
           | ({WIDTH{strobe.useXor}}   & (opA ^ opB))
           | ({WIDTH{strobe.useNor}}   & ~(opA | opB))
           | ({WIDTH{strobe.useShift}} & shiftVal);
    result[0] = result[0] | (strobe.useLtU & lessU) | (strobe.useLtS & lessS);
  end

endmodule

// File: rtl/alu_onehot.sv
module alu_onehot
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [NUM_OPS-1:0] opSel,
  input  logic [SHW-1:0]     shAmt,
  output logic [WIDTH-1:0]   result
);

  aluStrobe_t strobe;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .shAmt  (shAmt),
    .strobe (strobe),
    .result (result)
  );

endmodule

// File: rtl/alu_onehot_chk.sv
module alu_onehot_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [NUM_OPS-1:0] opSel,
  input logic [SHW-1:0]     shAmt,
  input logic [WIDTH-1:0]   result
);

  logic known;
  assign known = !$isunknown({opA, opB, opSel, shAmt, result});

  always_comb begin
    if (known && $onehot0(opSel)) begin
      // R12: idle selects give a zero word
      if (opSel == '0)
        assert_idle_zero_R12: assert (result == '0);
      // R7: compare results never set upper bits
      if (opSel[OP_SLT] || opSel[OP_SLTU])
        assert_set_upper_clear_R7: assert (result[WIDTH-1:1] == '0);
      // R1: sum minus one operand gives back the other
      if (opSel[OP_ADD])
        assert_add_inverse_R1: assert (result - opB == opA);
      // R2: difference plus subtrahend gives back the minuend
      if (opSel[OP_SUB])
        assert_sub_inverse_R2: assert (result + opB == opA);
      // R11: zero-distance shift returns opB
      if ((opSel[OP_SLL] || opSel[OP_SRL] || opSel[OP_SRA]) && shAmt == '0)
        assert_shift_zero_R11: assert (result == opB);
      // R9: arithmetic right shift keeps the sign bit
      if (opSel[OP_SRA])
        assert_sra_sign_R9: assert (result[WIDTH-1] == opB[WIDTH-1]);
      // R10: left shift by a nonzero distance clears bit 0
      if (opSel[OP_SLL] && shAmt != '0)
        assert_sll_low_zero_R10: assert (result[0] == 1'b0);
    end
  end

endmodule

bind alu_onehot alu_onehot_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_onehot_tb.sv
module alu_onehot_tb;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [10:0] opSel = '0;
  logic [4:0]  shAmt = '0;
  logic [31:0] result;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu_onehot u_dut (
    .opA    (opA),
    .opB    (opB),
    .opSel  (opSel),
    .shAmt  (shAmt),
    .result (result)
  );

  function automatic logic [31:0] refModel(int op, logic [31:0] a, logic [31:0] b,
                                           logic [4:0] sh);
    case (op)
      OP_ADD:  return a + b;
      OP_AND:  return a & b;
      OP_XOR:  return a ^ b;
      OP_OR:   return a | b;
      OP_NOR:  return ~(a | b);
      OP_SUB:  return a - b;
      OP_SLTU: return (a < b) ? 32'd1 : 32'd0;
      OP_SLT:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      OP_SRA:  return 32'($signed(b) >>> sh);
      OP_SRL:  return b >> sh;
      OP_SLL:  return b << sh;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqTag(int op);
    case (op)
      OP_ADD:  return "R1";
      OP_SUB:  return "R2";
      OP_AND, OP_XOR, OP_OR: return "R3";
      OP_NOR:  return "R4";
      OP_SLTU: return "R5";
      OP_SLT:  return "R6";
      OP_SRA:  return "R9";
      OP_SRL:  return "R8";
      OP_SLL:  return "R10";
      default: return "R12";
    endcase
  endfunction

  // op < 0 means no select raised
  task automatic applyCheck(int op, logic [31:0] a, logic [31:0] b, logic [4:0] sh,
                            string tag);
    logic [31:0] expv;
    @(posedge clk);
    #2;
    opA   = a;
    opB   = b;
    shAmt = sh;
    opSel = (op < 0) ? 11'd0 : (11'd1 << op);
    expv  = refModel(op, a, b, sh);
    @(negedge clk);
    compared++;
    if (result !== expv) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d actual=%h expected=%h",
               tag, op, a, b, sh, result, expv);
    end
  endtask

  task automatic testIdle();
    applyCheck(-1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, "R12");
    applyCheck(-1, 32'h1234_5678, 32'h8000_0000, 5'd0, "R12 R13");
  endtask

  task automatic testEdges();
    logic [31:0] edgeVal [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};
    for (int op = 0; op < NUM_OPS; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          applyCheck(op, edgeVal[i], edgeVal[j], (i + j) % 2 == 0 ? 5'd0 : 5'd31,
                     reqTag(op));
  endtask

  task automatic testSltOverflow();
    // R6: difference overflows, sign of difference alone would mislead
    applyCheck(OP_SLT, 32'h8000_0000, 32'h0000_0001, 5'd0, "R6");
    applyCheck(OP_SLT, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R6");
    applyCheck(OP_SLT, 32'h8000_0001, 32'h7FFF_FFFF, 5'd0, "R6 R7");
    applyCheck(OP_SLTU, 32'h8000_0000, 32'h0000_0001, 5'd0, "R5 R7");
  endtask

  task automatic testShiftSource();
    // R11: opA changes, shift result stays tied to opB
    for (int sh = 0; sh < 32; sh++) begin
      applyCheck(OP_SRA, 32'hFFFF_FFFF, 32'h9ABC_DEF0, 5'(sh), "R9 R11");
      applyCheck(OP_SRL, 32'h0000_0000, 32'h9ABC_DEF0, 5'(sh), "R8 R11");
      applyCheck(OP_SLL, 32'hA5A5_A5A5, 32'h9ABC_DEF1, 5'(sh), "R10 R11");
      applyCheck(OP_SRA, 32'h8000_0000, 32'h4ABC_DEF0, 5'(sh), "R9");
    end
  endtask

  task automatic testRandom();
    for (int n = 0; n < 400; n++) begin
      int op = n % NUM_OPS;
      applyCheck(op, $urandom, $urandom, 5'($urandom), reqTag(op));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    testIdle();
    testEdges();
    testSltOverflow();
    testShiftSource();
    testRandom();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule